// File: doc/BRIEF.md
# Dual-Style Parallel Host Port for a Character Display Controller

This block receives host bus cycles for a character display controller. It samples an external 8-bit data bus and two control lines on the system clock, and it turns each completed host write into a single byte with a register-select flag. It serves two bus styles, chosen by a static input. The enable style has a read/write line and an enable strobe. The strobe style has separate active-low write and read strobes. Every input passes through a two-flop synchronizer, and the port finds strobe edges on the synchronized copies. The host is never told to wait, so back-to-back cycles are always accepted.

A host read raises a one-clock request towards the controller. The port captures the byte the controller returns and drives it onto the bus, with an output enable, while the read strobe stays active. The port watches its own instruction stream for the function-set instruction. Bit 4 of that instruction picks the bus width. In narrow (4-bit) mode each byte takes two transfers on the upper four data lines, high nibble first, for both writes and reads.

Top module: `dual_bus_host_port`

## Requirements
- R1: After reset `wr_valid`, `rd_req` and `bus_db_oe` are low, `bus_db_out` is 0, and the bus width is 8 bits: a single write transfer produces a byte.
- R2: With `bus_mode` = 0 (enable style), a falling edge of `bus_ctl_b` (enable) while `bus_ctl_a` (read/write) is low yields exactly one `wr_valid` pulse. The pulse carries the data lines in `wr_data` and the select line in `wr_rs` (0 = instruction, 1 = data).
- R3: With `bus_mode` = 0, a rising edge of enable while read/write is high yields one `rd_req` pulse with `rd_rs` equal to the select line. The byte returned on `rd_data` is then driven on `bus_db_out` with `bus_db_oe` high until enable falls, after which `bus_db_oe` goes low.
- R4: With `bus_mode` = 1 (strobe style), a rising edge of `bus_ctl_a` (active-low write strobe) yields exactly one `wr_valid` pulse carrying the data lines and the select line.
- R5: With `bus_mode` = 1, a falling edge of `bus_ctl_b` (active-low read strobe) yields one `rd_req` pulse. The returned byte is driven with `bus_db_oe` high until the read strobe rises again.
- R6: A read cycle produces no `wr_valid`, and a write cycle produces no `rd_req`, in either bus style.
- R7: A written instruction (select 0) whose bits 7:5 are 001 sets the bus width from its bit 4: 0 selects 4-bit and 1 selects 8-bit. When the width changes, the nibble phase returns to "high nibble next".
- R8: In 4-bit mode a write byte takes two transfers. The first gives bits 7:4 and the second gives bits 3:0, each taken from data lines 7:4, and data lines 3:0 are ignored. `wr_valid` pulses only after the second transfer, and `wr_rs` comes from the second transfer.
- R9: In 4-bit mode only the first read strobe of a pair raises `rd_req`. The first strobe drives the high nibble of the returned byte on `bus_db_out[7:4]`, the second drives the low nibble there, and `bus_db_out[3:0]` is 0.
- R10: Write strobes whose high and low levels each last two clock cycles are all captured, in order, with no byte lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode | input | 1 | Static bus style: 0 enable style, 1 strobe style |
| bus_rs | input | 1 | Register select: 0 instruction, 1 data |
| bus_ctl_a | input | 1 | Read/write line (enable style) or active-low write strobe (strobe style) |
| bus_ctl_b | input | 1 | Enable (enable style) or active-low read strobe (strobe style) |
| bus_db_in | input | 8 | Data lines driven by the host |
| bus_db_out | output | 8 | Read data driven towards the host |
| bus_db_oe | output | 1 | Output enable for `bus_db_out` |
| wr_valid | output | 1 | One-clock pulse: a byte is complete |
| wr_rs | output | 1 | Select flag of the completed byte |
| wr_data | output | 8 | Completed byte |
| rd_req | output | 1 | One-clock pulse: the host asks for a byte |
| rd_rs | output | 1 | Select flag of the read request |
| rd_data | input | 8 | Byte returned by the controller, valid the cycle after `rd_req` |

## Verification
A wrong nibble phase is the most damaging internal fault. It shows up on the very next narrow transfer: a write byte appears one transfer early, or a read request is raised on the second strobe of a pair. A width flag that misses or misdecodes the function-set instruction shows up on the first write after it, because a single transfer then either produces a byte or does not. A lost or doubled strobe edge shows up within about four clocks of the edge, as a missing or repeated `wr_valid` or `rd_req` pulse. A stale read-byte register shows up as a wrong `bus_db_out` value while the strobe is still active.

// File: rtl/hp_pkg.sv
package hp_pkg;
  // bus style selected by the static mode input
  typedef enum logic {
    STYLE_ENABLE = 1'b0,
    STYLE_STROBE = 1'b1
  } bus_style_e;

  // edge events found on the synchronized control lines
  typedef struct packed {
    logic wr;
    logic rd_start;
    logic rd_end;
  } bus_evt_t;

  // function-set instruction: top three bits carry this tag
  localparam int       FSET_TAG_W = 3;
  localparam logic [FSET_TAG_W-1:0] FSET_TAG = 3'b001;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= rst_val;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hp_edge_decode.sv
module hp_edge_decode
  import hp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode,
  input  logic [1:0] ctl_now,   // [1] = line b, [0] = line a
  output logic [1:0] ctl_prev,
  output bus_evt_t   evt
);
  bus_style_e style;
  assign style = bus_style_e'(mode);

  // previous sample; idle level depends on the style
  always_ff @(posedge clk) begin
    if (rst) ctl_prev <= {2{mode}};
    else     ctl_prev <= ctl_now;
  end

  always_comb begin
    evt = '0;
    if (style == STYLE_ENABLE) begin
      // line a = read/write (high = read), line b = enable
      evt.wr       =  ctl_prev[1] & ~ctl_now[1] & ~ctl_prev[0];
      evt.rd_start = ~ctl_prev[1] &  ctl_now[1] &  ctl_prev[0];
      evt.rd_end   =  ctl_prev[1] & ~ctl_now[1];
    end else begin
      // line a = write strobe (low active), line b = read strobe (low active)
      evt.wr       = ~ctl_prev[0] &  ctl_now[0];
      evt.rd_start =  ctl_prev[1] & ~ctl_now[1];
      evt.rd_end   = ~ctl_prev[1] &  ctl_now[1];
    end
  end
endmodule

// File: rtl/hp_nibble_join.sv
module hp_nibble_join
  import hp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_evt_t          evt,
  input  logic              rs_in,
  input  logic [DATA_W-1:0] db_in,
  output logic              wr_valid,
  output logic              wr_rs,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic              rd_rs,
  output logic              wide,
  output logic              phase_hi
);
  localparam int NIB_W  = DATA_W / 2;
  localparam int DL_BIT = DATA_W - 4;

  logic [NIB_W-1:0]  hi_q, nxt_hi;
  logic              nxt_phase, nxt_wide;
  logic              asm_valid, fetch, is_fset;
  logic [DATA_W-1:0] asm_byte;

  always_comb begin
    asm_valid = 1'b0;
    asm_byte  = db_in;
    nxt_phase = phase_hi;
    nxt_hi    = hi_q;
    fetch     = 1'b0;
    if (evt.wr) begin
      if (wide) begin
        asm_valid = 1'b1;
      end else if (phase_hi) begin
        nxt_hi    = db_in[DATA_W-1 -: NIB_W];
        nxt_phase = 1'b0;
      end else begin
        asm_valid = 1'b1;
        asm_byte  = {hi_q, db_in[DATA_W-1 -: NIB_W]};
        nxt_phase = 1'b1;
      end
    end else if (evt.rd_start) begin
      fetch = wide | phase_hi;
      if (!wide) nxt_phase = ~phase_hi;
    end
    is_fset  = asm_valid & ~rs_in &
               (asm_byte[DATA_W-1 -: FSET_TAG_W] == FSET_TAG);
    nxt_wide = is_fset ? asm_byte[DL_BIT] : wide;
    if (nxt_wide != wide) nxt_phase = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wide     <= 1'b1;
      phase_hi <= 1'b1;
      hi_q     <= '0;
      wr_valid <= 1'b0;
      wr_rs    <= 1'b0;
      wr_data  <= '0;
      rd_req   <= 1'b0;
      rd_rs    <= 1'b0;
    end else begin
      wide     <= nxt_wide;
      phase_hi <= nxt_phase;
      hi_q     <= nxt_hi;
      wr_valid <= asm_valid;
      rd_req   <= fetch;
      if (asm_valid) begin
        wr_rs   <= rs_in;
        wr_data <= asm_byte;
      end
      if (fetch) rd_rs <= rs_in;
    end
  end
endmodule

// File: rtl/hp_read_drive.sv
module hp_read_drive
  import hp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_evt_t          evt,
  input  logic              wide,
  input  logic              phase_hi,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] db_out,
  output logic              db_oe
);
  localparam int NIB_W = DATA_W / 2;

  logic              active_q, pend_q, ready_q, low_q, wide_q;
  logic [DATA_W-1:0] byte_q, shown;

  always_comb begin
    if (wide_q)     shown = byte_q;
    else if (low_q) shown = {byte_q[NIB_W-1:0], {NIB_W{1'b0}}};
    else            shown = {byte_q[DATA_W-1 -: NIB_W], {NIB_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      ready_q  <= 1'b0;
      low_q    <= 1'b0;
      wide_q   <= 1'b1;
      byte_q   <= '0;
      db_out   <= '0;
      db_oe    <= 1'b0;
    end else begin
      pend_q <= rd_req;
      if (evt.rd_start) begin
        active_q <= 1'b1;
        wide_q   <= wide;
        low_q    <= ~wide & ~phase_hi;
        if (wide | phase_hi) ready_q <= 1'b0;
      end else if (evt.rd_end) begin
        active_q <= 1'b0;
      end
      if (pend_q) begin
        byte_q  <= rd_data;
        ready_q <= 1'b1;
      end
      db_oe  <= active_q & ready_q;
      db_out <= (active_q & ready_q) ? shown : '0;
    end
  end
endmodule

// File: rtl/dual_bus_host_port.sv
module dual_bus_host_port
  import hp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_mode,
  input  logic              bus_rs,
  input  logic              bus_ctl_a,
  input  logic              bus_ctl_b,
  input  logic [DATA_W-1:0] bus_db_in,
  output logic [DATA_W-1:0] bus_db_out,
  output logic              bus_db_oe,
  output logic              wr_valid,
  output logic              wr_rs,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic              rd_rs,
  input  logic [DATA_W-1:0] rd_data
);
  localparam int PAY_W = DATA_W + 1;

  logic [1:0]       ctl_now, ctl_prev;
  logic [PAY_W-1:0] pay_q;
  bus_evt_t         evt;
  logic             join_wide, join_phase_hi;

  // control lines: SYNC_STAGES deep, idle level per style
  hp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync_ctl (
    .clk(clk), .rst(rst), .rst_val({2{bus_mode}}),
    .d({bus_ctl_b, bus_ctl_a}), .q(ctl_now)
  );

  // payload one stage deeper: aligned with the sample before the edge
  hp_sync #(.W(PAY_W), .STAGES(SYNC_STAGES + 1)) u_sync_pay (
    .clk(clk), .rst(rst), .rst_val('0),
    .d({bus_rs, bus_db_in}), .q(pay_q)
  );

  hp_edge_decode u_edge (
    .clk(clk), .rst(rst), .mode(bus_mode),
    .ctl_now(ctl_now), .ctl_prev(ctl_prev), .evt(evt)
  );

  hp_nibble_join #(.DATA_W(DATA_W)) u_join (
    .clk(clk), .rst(rst), .evt(evt),
    .rs_in(pay_q[DATA_W]), .db_in(pay_q[DATA_W-1:0]),
    .wr_valid(wr_valid), .wr_rs(wr_rs), .wr_data(wr_data),
    .rd_req(rd_req), .rd_rs(rd_rs),
    .wide(join_wide), .phase_hi(join_phase_hi)
  );

  hp_read_drive #(.DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst(rst), .evt(evt),
    .wide(join_wide), .phase_hi(join_phase_hi),
    .rd_req(rd_req), .rd_data(rd_data),
    .db_out(bus_db_out), .db_oe(bus_db_oe)
  );
endmodule

// File: rtl/hp_port_checker.sv
module hp_port_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_rs,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_req,
  input logic              db_oe,
  input logic              wide,
  input logic              phase_hi
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wr_valid && !rd_req && !db_oe));

  p_wr_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  p_rd_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  p_width_from_fset_r7: assert property (@(posedge clk) disable iff (rst)
    (wide != $past(wide)) |-> (wr_valid && !wr_rs &&
      wr_data[DATA_W-1 -: 3] == 3'b001 && wr_data[DATA_W-4] == wide));

  p_byte_closes_pair_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wide) |-> phase_hi);

  p_fetch_on_first_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !wide) |-> !phase_hi);
endmodule

bind dual_bus_host_port hp_port_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_rs(wr_rs),
  .wr_data(wr_data), .rd_req(rd_req), .db_oe(bus_db_oe),
  .wide(join_wide), .phase_hi(join_phase_hi)
);

// File: tb/dual_bus_host_port_test.sv
module dual_bus_host_port_test;
  localparam int CLK_P = 10;
  localparam int NV    = 8;
  // {rs, byte}; no function-set instruction with bit 4 = 0 in this table
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 8'h01}, {1'b1, 8'h41}, {1'b1, 8'hFF}, {1'b0, 8'h80},
    {1'b1, 8'h00}, {1'b0, 8'h38}, {1'b1, 8'h5A}, {1'b0, 8'h0C}
  };

  logic       clk = 1'b0, rst = 1'b1, mode = 1'b0;
  logic       rs = 1'b0, ca = 1'b0, cb = 1'b0;
  logic [7:0] db = 8'h00, rdat = 8'h00;
  logic [7:0] db_out, wr_data;
  logic       db_oe, wr_valid, wr_rs, rd_req, rd_rs;

  int total = 0, bad = 0;
  int ev_n = 0, rq_n = 0;
  logic [7:0] ev_data [64];
  logic       ev_rs   [64];
  logic       last_rd_rs = 1'b0;
  bit         done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dual_bus_host_port uut (
    .clk(clk), .rst(rst), .bus_mode(mode), .bus_rs(rs),
    .bus_ctl_a(ca), .bus_ctl_b(cb), .bus_db_in(db),
    .bus_db_out(db_out), .bus_db_oe(db_oe),
    .wr_valid(wr_valid), .wr_rs(wr_rs), .wr_data(wr_data),
    .rd_req(rd_req), .rd_rs(rd_rs), .rd_data(rdat)
  );

  always @(negedge clk) begin
    if (wr_valid && ev_n < 64) begin
      ev_data[ev_n] = wr_data;
      ev_rs[ev_n]   = wr_rs;
      ev_n++;
    end
    if (rd_req) begin
      rq_n++;
      last_rd_rs = rd_rs;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic do_reset(logic m);
    @(negedge clk);
    rst = 1'b1; mode = m; ca = m; cb = m; rs = 1'b0; db = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // one write transfer in the current style
  task automatic host_write(logic r, logic [7:0] d, int lvl);
    @(negedge clk);
    rs = r; db = d;
    if (mode) ca = 1'b0; else begin ca = 1'b0; cb = 1'b1; end
    repeat (lvl) @(negedge clk);
    if (mode) ca = 1'b1; else cb = 1'b0;
    repeat (lvl) @(negedge clk);
  endtask

  // begin a read transfer; strobe left active
  task automatic read_begin(logic r);
    @(negedge clk);
    rs = r;
    if (!mode) ca = 1'b1;
    repeat (3) @(negedge clk);
    if (mode) cb = 1'b0; else cb = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic read_end();
    if (mode) cb = 1'b1; else cb = 1'b0;
    repeat (6) @(negedge clk);
    if (!mode) ca = 1'b0;
  endtask

  task automatic write_chk(string req, logic r, logic [7:0] d, logic er, logic [7:0] ed);
    int n0 = ev_n;
    host_write(r, d, 3);
    repeat (4) @(negedge clk);
    check({req, " count"}, ev_n - n0, 1);
    if (ev_n > n0) begin
      check({req, " data"}, ev_data[ev_n-1], ed);
      check({req, " rs"}, ev_rs[ev_n-1], er);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    total++; bad++;
    finish_up();
  end

  initial begin
    int n0, q0;
    do_reset(1'b0);
    // R1 reset state
    check("R1 wr_valid", wr_valid, 0);
    check("R1 rd_req", rd_req, 0);
    check("R1 oe", db_oe, 0);
    check("R1 db_out", db_out, 0);

    // R2 table walk, enable style
    for (int i = 0; i < NV; i++)
      write_chk("R2", VEC[i][8], VEC[i][7:0], VEC[i][8], VEC[i][7:0]);

    // R6: read cycle gives no write; write gives no request
    rdat = 8'h9C;
    n0 = ev_n; q0 = rq_n;
    read_begin(1'b1);
    // R3 read in enable style
    check("R3 rd_req count", rq_n - q0, 1);
    check("R3 rd_rs", last_rd_rs, 1);
    check("R3 oe", db_oe, 1);
    check("R3 db_out", db_out, 8'h9C);
    read_end();
    check("R3 oe off", db_oe, 0);
    check("R6 no write on read", ev_n - n0, 0);
    q0 = rq_n;
    host_write(1'b0, 8'h12, 3);
    repeat (4) @(negedge clk);
    check("R6 no request on write", rq_n - q0, 0);

    // R7 switch to 4-bit, R8 nibble joining
    write_chk("R7 fset", 1'b0, 8'h28, 1'b0, 8'h28);
    n0 = ev_n;
    host_write(1'b1, 8'hA3, 3);
    repeat (4) @(negedge clk);
    check("R8 no byte after first nibble", ev_n - n0, 0);
    write_chk("R8 joined", 1'b1, 8'h5C, 1'b1, 8'hA5);
    host_write(1'b0, 8'hC0, 3);
    write_chk("R8 rs from second", 1'b1, 8'h3F, 1'b1, 8'hC3);

    // R9 4-bit read
    rdat = 8'h3C;
    q0 = rq_n;
    read_begin(1'b0);
    check("R9 first req", rq_n - q0, 1);
    check("R9 high nibble", db_out, 8'h30);
    read_end();
    rdat = 8'hEE;
    read_begin(1'b0);
    check("R9 no second req", rq_n - q0, 1);
    check("R9 low nibble", db_out, 8'hC0);
    read_end();

    // R7 back to 8-bit through two nibbles
    host_write(1'b0, 8'h30, 3);
    write_chk("R7 fset wide", 1'b0, 8'h80, 1'b0, 8'h38);
    write_chk("R7 single transfer byte", 1'b1, 8'h77, 1'b1, 8'h77);

    // R1 width after reset is 8-bit
    write_chk("R7 fset narrow", 1'b0, 8'h20, 1'b0, 8'h20);
    do_reset(1'b0);
    write_chk("R1 width after reset", 1'b1, 8'h66, 1'b1, 8'h66);

    // strobe style
    do_reset(1'b1);
    for (int i = 0; i < NV; i++)
      write_chk("R4", ~VEC[i][8], ~VEC[i][7:0], ~VEC[i][8], ~VEC[i][7:0]);
    rdat = 8'h47;
    n0 = ev_n; q0 = rq_n;
    read_begin(1'b0);
    check("R5 rd_req count", rq_n - q0, 1);
    check("R5 rd_rs", last_rd_rs, 0);
    check("R5 oe", db_oe, 1);
    check("R5 db_out", db_out, 8'h47);
    read_end();
    check("R5 oe off", db_oe, 0);
    check("R6 strobe style no write on read", ev_n - n0, 0);

    // R10 back-to-back with two-clock levels
    n0 = ev_n; q0 = rq_n;
    for (int i = 0; i < 4; i++) host_write(i[0], 8'hB0 + 8'(i), 2);
    repeat (6) @(negedge clk);
    check("R10 count", ev_n - n0, 4);
    for (int i = 0; i < 4; i++)
      if (n0 + i < 64) check("R10 order", ev_data[n0+i], 8'hB0 + 8'(i));
    check("R6 strobe style no request on write", rq_n - q0, 0);

    finish_up();
  end
endmodule